// File: doc/BRIEF.md
# Compressor-Tree Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits, 8 by default, and returns the full `2*W`-bit product. It works in three stages. The first stage is an AND array that forms `W` shifted partial-product rows. The second stage is a carry-save tree of 4:2 compressor cells that halves the row count at each level until two rows are left. The third stage is one carry-propagate addition that merges those two rows.

Each compressor cell takes four bits of equal weight plus a lateral carry-in. It returns a sum bit, a carry bit and a lateral carry-out. The carry-out depends only on the four main bits. So, along a row of cells, no carry ripples further than one column. Inside the cell, gates with both polarities (XOR and XNOR) feed multiplexers that pick the outputs.

The product is combinational by default. The parameter `REG_OUT` inserts one output register, which has a synchronous clear.

Top module: `cmp_tree_mul`

## Requirements
- R1: For every pair of operands, `p` equals `a*b` exactly, over all `2*W` bits.
- R2: For each of the 32 input patterns of a compressor cell, x1+x2+x3+x4+ci equals s + 2*(c + co).
- R3: The cell's lateral carry-out `co` is the same for ci=0 and ci=1, whatever x1..x4 are.
- R4: The cell's `co` is x3 when x1 differs from x2, and x1 when they are equal.
- R5: At every tree level, each group of four rows and the two rows it produces have the same sum modulo 2^(2*W).
- R6: With REG_OUT=1, after a rising edge with rst low, `p` shows the product of the operands sampled at that edge.
- R7: With REG_OUT=1, a rising edge with rst high clears `p` to zero.
- R8: With REG_OUT=0, `p` follows the operands without waiting for a clock edge, and `clk` and `rst` have no effect on it.
- R9: The boundary operands give the stated products: 0 times any value gives 0, 1*x gives x, and 255*255 gives 65025 (W=8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high clear of the output register |
| a | input | W | Multiplicand, unsigned |
| b | input | W | Multiplier, unsigned |
| p | output | 2*W | Product |

## Verification
In the combinational build, the product is due in the same cycle the operands change. The bench sets new operands just after a falling edge and reads them back 1 ns later, before any clock edge can act. In the registered build, the product is due one rising edge after the operands are applied. So each read of that output is checked against the operands from the previous falling edge. A clear is checked at the falling edge that follows the rising edge on which rst was high. The compressor cell is driven on its own, with no clock, and every pattern is read 1 ns after it is applied.

// File: rtl/mul_cmp42.sv
module mul_cmp42 (
  input  logic x1,
  input  logic x2,
  input  logic x3,
  input  logic x4,
  input  logic ci,
  output logic s,
  output logic c,
  output logic co
);
  logic t1, t1n, t2, t2n, pp, ppn;

  assign t1  = x1 ^ x2;
  assign t1n = ~(x1 ^ x2);
  assign t2  = x3 ^ x4;
  assign t2n = ~(x3 ^ x4);
  assign pp  = t1 ? t2n : t2;
  assign ppn = t1 ? t2 : t2n;

  assign co = t1n ? x1 : x3;
  assign s  = pp ? ~ci : ci;
  assign c  = ppn ? x4 : ci;
endmodule

// File: rtl/cmp_tree_mul.sv
module cmp_tree_mul #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;
  localparam int LV = $clog2(W) - 1;
  localparam int NR = 2 * W - 2;

  logic [PW-1:0] row [NR];
  logic [PW-1:0] sum, q;

  for (genvar j = 0; j < W; j++) begin : g_pp
    assign row[j] = PW'(a & {W{b[j]}}) << j;
  end

  for (genvar k = 1; k <= LV; k++) begin : g_lvl
    localparam int IN0 = PW - (PW >> (k - 1));
    localparam int OUT0 = PW - (PW >> k);
    localparam int NG = W >> (k + 1);
    for (genvar g = 0; g < NG; g++) begin : g_grp
      logic [PW-1:0] s_v, c_v, co_v, in_sum, out_sum;
      logic unused_top;
      for (genvar i = 0; i < PW; i++) begin : g_bit
        logic cin;
        if (i == 0) begin : g_lsb
          assign cin = 1'b0;
        end else begin : g_up
          assign cin = co_v[i-1];
        end
        mul_cmp42 u_cell (
          .x1(row[IN0+4*g][i]),
          .x2(row[IN0+4*g+1][i]),
          .x3(row[IN0+4*g+2][i]),
          .x4(row[IN0+4*g+3][i]),
          .ci(cin),
          .s (s_v[i]),
          .c (c_v[i]),
          .co(co_v[i])
        );
      end
      assign row[OUT0+2*g]   = s_v;
      assign row[OUT0+2*g+1] = {c_v[PW-2:0], 1'b0};
      assign unused_top      = c_v[PW-1] ^ co_v[PW-1];

      assign in_sum  = row[IN0+4*g] + row[IN0+4*g+1] + row[IN0+4*g+2] + row[IN0+4*g+3];
      assign out_sum = row[OUT0+2*g] + row[OUT0+2*g+1];

      a_r5_level_sum: assert property (@(posedge clk) disable iff (rst)
        in_sum == out_sum);
    end
  end

  assign sum = row[NR-2] + row[NR-1];

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= sum;
  end

  assign p = REG_OUT ? q : sum;

  a_r1_exact_product: assert property (@(posedge clk) disable iff (rst)
    sum == PW'(a) * PW'(b));

  a_r7_sync_clear: assert property (@(posedge clk)
    rst |=> (q == '0));

  a_r6_one_edge: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (q == PW'($past(a)) * PW'($past(b))));
endmodule

// File: tb/sim_cmp_tree_mul.sv
module sim_cmp_tree_mul;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  a = '0, b = '0;
  logic [15:0] p_reg, p_cmb;
  logic        x1, x2, x3, x4, ci, cs, cc, cco;
  int          errs = 0, nchk = 0;

  always #(CLK_P/2) clk = ~clk;

  cmp_tree_mul #(.W(8), .REG_OUT(1'b1)) u0 (.clk(clk), .rst(rst), .a(a), .b(b), .p(p_reg));
  cmp_tree_mul #(.W(8), .REG_OUT(1'b0)) u1 (.clk(clk), .rst(rst), .a(a), .b(b), .p(p_cmb));
  mul_cmp42 c0 (.x1(x1), .x2(x2), .x3(x3), .x4(x4), .ci(ci), .s(cs), .c(cc), .co(cco));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setab(input int va, input int vb);
    @(negedge clk);
    a = va[7:0];
    b = vb[7:0];
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++;
    nchk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    x1 = 0; x2 = 0; x3 = 0; x4 = 0; ci = 0;
    for (int v = 0; v < 32; v++) begin
      {x1, x2, x3, x4, ci} = v[4:0];
      #1;
      chk(int'(x1) + x2 + x3 + x4 + ci == int'(cs) + 2 * (int'(cc) + cco), "R2 cell count",
          int'(cs) + 2 * (int'(cc) + cco), int'(x1) + x2 + x3 + x4 + ci);
      chk(cco == ((x1 != x2) ? x3 : x1), "R4 cell carry-out", cco, (x1 != x2) ? x3 : x1);
    end
    for (int v = 0; v < 16; v++) begin
      logic co0;
      {x1, x2, x3, x4} = v[3:0];
      ci = 1'b0;
      #1;
      co0 = cco;
      ci = 1'b1;
      #1;
      chk(cco == co0, "R3 carry-out independent of ci", cco, co0);
    end

    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(p_reg == 16'd0, "R7 reset state", p_reg, 0);
    rst = 1'b0;

    setab(0, 255);  chk(p_cmb == 16'd0, "R9 zero operand", p_cmb, 0);
    setab(1, 173);  chk(p_cmb == 16'd173, "R9 unit operand", p_cmb, 173);
    chk(p_reg == 16'd0, "R6 previous product", p_reg, 0);
    setab(255, 255); chk(p_cmb == 16'd65025, "R9 max operands", p_cmb, 65025);
    chk(p_reg == 16'd173, "R6 previous product", p_reg, 173);

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(p_reg == 16'd0, "R7 sync clear", p_reg, 0);
    chk(p_cmb == 16'd65025, "R8 clock and reset ignored", p_cmb, 65025);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(p_reg == 16'd65025, "R6 after clear", p_reg, 65025);

    begin
      int prev;
      prev = 255 * 255;
      for (int ia = 0; ia < 256; ia++) begin
        for (int ib = 0; ib < 256; ib++) begin
          setab(ia, ib);
          chk(p_cmb == 16'(ia * ib), "R1 R5 product", p_cmb, ia * ib);
          chk(p_reg == 16'(prev), "R6 registered product", p_reg, prev);
          prev = ia * ib;
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule